// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block gathers eight hardware interrupt requests into a pending register and decides, at each instruction boundary reported by the CPU, whether one of them should be serviced. A request is eligible when its pending bit is set, its mask bit is 1 and the global enable is 1. Among the eligible requests the one with the highest index wins. The block then emits a one-cycle vector strobe with the address of that source's pointer slot, clears the winning pending bit and drops the global enable.

The mask is not a separate register. It is the low byte of a 16-bit status word kept inside the block, and the global enable is bit 9 of that word. A push-flags strobe clears the whole word. A pop-flags strobe reloads the word from the CPU. After a pop, the boundary that ends the pop instruction itself is never taken, so one more instruction always completes before a vector can be taken. Software can read and write the pending register and the mask through a small register port, and can load the full status word directly.

Top module: `irq_vec_ctrl`

## Requirements
- R1: After synchronous reset, the pending register, the status word `psw_q` and `vec_take` are all zero.
- R2: A 1 on `irq_hw[n]` for one cycle sets pending bit n. The bit stays set until its vector is taken or software overwrites it. `reg_rdata` with `reg_sel`=0 shows the pending register two clock edges after `reg_sel` is applied.
- R3: A vector is taken only at a clock edge where `insn_bnd` is 1, the pending and mask bits of some source are both 1, and `psw_q[9]` is 1. Without a boundary strobe, nothing is taken.
- R4: When several sources are eligible, the source with the highest index (7 down to 0) is taken.
- R5: On the edge that takes source n, `vec_take` goes to 1 for exactly one cycle, `vec_src` becomes n and `vec_addr` becomes 16'h2000 + 2n.
- R6: Taking source n clears pending bit n and `psw_q[9]`. All other pending bits and all other status-word bits keep their values.
- R7: The mask is `psw_q[7:0]`. A register write with `reg_sel`=1 replaces only those 8 bits, and `reg_rdata` with `reg_sel`=1 returns them.
- R8: `push_flags` sets the whole status word to zero on that edge, so no vector is taken until the enable is set again.
- R9: `pop_flags` loads `pop_data` into the status word. The first boundary at or after the pop (ending the pop instruction) takes no vector. The boundary after that one may take a vector.
- R10: A software write to the pending register and a hardware set of the same bit in the same cycle leave the bit set.
- R11: A request that arrives while its mask bit is 0 stays pending, and it is taken at a later boundary once the mask bit is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_hw | input | 8 | Hardware event pulses, one per source |
| insn_bnd | input | 1 | Instruction-boundary strobe from the CPU |
| push_flags | input | 1 | Push-flags strobe; clears the status word |
| pop_flags | input | 1 | Pop-flags strobe; loads `pop_data` |
| pop_data | input | 16 | Status word restored by a pop |
| psw_we | input | 1 | Direct load of the status word |
| psw_wdata | input | 16 | Status word value for `psw_we` |
| reg_we | input | 1 | Register-port write enable |
| reg_sel | input | 1 | Register select: 0 pending, 1 mask |
| reg_wdata | input | 8 | Register-port write data |
| reg_rdata | output | 8 | Registered read data of the selected register |
| psw_q | output | 16 | Current status word |
| vec_take | output | 1 | One-cycle strobe: vector taken |
| vec_src | output | 3 | Index of the taken source |
| vec_addr | output | 16 | Pointer-slot address of the taken source |

## Verification
The selection logic is driven with a single pending source, with a mix of three pending sources drained one at a time, and with a source that is pending but masked. These show that the highest index wins, that the served bit alone clears, and that a masked request waits rather than being dropped. Requests are also left pending with no boundary strobe, and are raised after a push and around a pop. This separates the boundary qualification, the cleared enable and the one-instruction shadow. The two pop timings (pop together with its boundary, and pop before its boundary) show that exactly one boundary is skipped. Simultaneous software writes and hardware sets on the pending register show which one has precedence.

// File: rtl/irq_ctrl_pkg.sv
package irq_ctrl_pkg;
  localparam int PSW_W  = 16;
  localparam int IE_POS = 9;

  typedef enum logic {
    SEL_PEND = 1'b0,
    SEL_MASK = 1'b1
  } reg_sel_e;
endpackage

// File: rtl/irq_pending.sv
module irq_pending #(
  parameter int N  = 8,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [N-1:0]  hw_set,
  input  logic          wr_en,
  input  logic [N-1:0]  wr_data,
  input  logic          clr_en,
  input  logic [IW-1:0] clr_idx,
  output logic [N-1:0]  pend_q
);
  logic [N-1:0] pend_d;

  always_comb begin
    pend_d = wr_en ? wr_data : pend_q;
    if (clr_en) pend_d[clr_idx] = 1'b0;
    pend_d = pend_d | hw_set;     // hardware set has the last word
  end

  always_ff @(posedge clk) begin
    if (rst) pend_q <= '0;
    else     pend_q <= pend_d;
  end

  p_hw_wins_r10: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> ((pend_q & $past(hw_set)) == $past(hw_set)));
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter #(
  parameter int N  = 8,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  req,
  output logic          any,
  output logic [IW-1:0] idx
);
  logic [N-1:0] above;   // above[i]: some request with index > i

  genvar g;
  generate
    for (g = 0; g < N; g++) begin : g_above
      if (g == N-1) begin : g_top
        assign above[g] = 1'b0;
      end else begin : g_rest
        assign above[g] = |req[N-1:g+1];
      end
    end
  endgenerate

  always_comb begin
    idx = '0;
    for (int i = 0; i < N; i++)
      if (req[i] && !above[i]) idx = IW'(i);
  end

  assign any = |req;
endmodule

// File: rtl/irq_psw.sv
module irq_psw
  import irq_ctrl_pkg::*;
#(
  parameter int MW = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             push,
  input  logic             pop,
  input  logic [PSW_W-1:0] pop_data,
  input  logic             ld,
  input  logic [PSW_W-1:0] ld_data,
  input  logic             mask_we,
  input  logic [MW-1:0]    mask_data,
  input  logic             take,
  input  logic             bnd,
  output logic [PSW_W-1:0] psw_q,
  output logic             shadow_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      psw_q    <= '0;
      shadow_q <= 1'b0;
    end else begin
      if (pop)       psw_q <= pop_data;
      else if (push) psw_q <= '0;
      else if (ld)   psw_q <= ld_data;
      else begin
        if (mask_we) psw_q[MW-1:0] <= mask_data;
        if (take)    psw_q[IE_POS] <= 1'b0;
      end
      // shadow: pop instruction not yet finished at a boundary
      if (pop)      shadow_q <= !bnd;
      else if (bnd) shadow_q <= 1'b0;
    end
  end

  p_push_clears_r8: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(push) && !$past(pop)) |-> (psw_q == '0));

  p_pop_loads_r9: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(pop)) |-> (psw_q == $past(pop_data)));
endmodule

// File: rtl/irq_vec_ctrl.sv
module irq_vec_ctrl
  import irq_ctrl_pkg::*;
#(
  parameter int          NSRC     = 8,
  parameter int          AW       = 16,
  parameter logic [15:0] VEC_BASE = 16'h2000,
  localparam int         IW       = (NSRC > 1) ? $clog2(NSRC) : 1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NSRC-1:0] irq_hw,
  input  logic            insn_bnd,
  input  logic            push_flags,
  input  logic            pop_flags,
  input  logic [15:0]     pop_data,
  input  logic            psw_we,
  input  logic [15:0]     psw_wdata,
  input  logic            reg_we,
  input  logic            reg_sel,
  input  logic [7:0]      reg_wdata,
  output logic [7:0]      reg_rdata,
  output logic [15:0]     psw_q,
  output logic            vec_take,
  output logic [IW-1:0]   vec_src,
  output logic [AW-1:0]   vec_addr
);
  reg_sel_e        sel;
  logic [NSRC-1:0] pend_q, elig;
  logic            any, shadow_q, take_go;
  logic [IW-1:0]   win;

  assign sel = reg_sel_e'(reg_sel);

  irq_pending #(.N(NSRC)) u_pend (
    .clk(clk), .rst(rst), .hw_set(irq_hw),
    .wr_en(reg_we && sel == SEL_PEND), .wr_data(reg_wdata[NSRC-1:0]),
    .clr_en(take_go), .clr_idx(win), .pend_q(pend_q)
  );

  assign elig = pend_q & psw_q[NSRC-1:0];

  irq_arbiter #(.N(NSRC)) u_arb (.req(elig), .any(any), .idx(win));

  assign take_go = insn_bnd && any && psw_q[IE_POS] && !shadow_q &&
                   !pop_flags && !push_flags && !psw_we;

  irq_psw #(.MW(NSRC)) u_psw (
    .clk(clk), .rst(rst), .push(push_flags), .pop(pop_flags),
    .pop_data(pop_data), .ld(psw_we), .ld_data(psw_wdata),
    .mask_we(reg_we && sel == SEL_MASK), .mask_data(reg_wdata[NSRC-1:0]),
    .take(take_go), .bnd(insn_bnd), .psw_q(psw_q), .shadow_q(shadow_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      vec_take  <= 1'b0;
      vec_src   <= '0;
      vec_addr  <= '0;
      reg_rdata <= '0;
    end else begin
      vec_take  <= take_go;
      if (take_go) begin
        vec_src  <= win;
        vec_addr <= AW'(VEC_BASE) + AW'({win, 1'b0});
      end
      reg_rdata <= (sel == SEL_MASK) ? 8'(psw_q[NSRC-1:0]) : 8'(pend_q);
    end
  end

  p_take_qualified_r3: assert property (@(posedge clk) disable iff (rst)
    vec_take |-> ($past(insn_bnd) && $past(psw_q[IE_POS])));

  p_take_clears_ie_r6: assert property (@(posedge clk) disable iff (rst)
    vec_take |-> !psw_q[IE_POS]);

  p_vec_slot_r5: assert property (@(posedge clk) disable iff (rst)
    vec_take |-> (vec_addr[0] == 1'b0 && vec_addr[IW:1] == vec_src));

  p_single_pulse_r5: assert property (@(posedge clk) disable iff (rst)
    vec_take |=> !vec_take);

  p_shadow_r9: assert property (@(posedge clk) disable iff (rst)
    $past(pop_flags) |-> !vec_take);
endmodule

// File: tb/tb_irq_vec_ctrl.sv
`timescale 1ns/1ps
module tb_irq_vec_ctrl;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  irq_hw = '0;
  logic        insn_bnd = 0, push_flags = 0, pop_flags = 0, psw_we = 0;
  logic [15:0] pop_data = '0, psw_wdata = '0;
  logic        reg_we = 0, reg_sel = 0;
  logic [7:0]  reg_wdata = '0, reg_rdata;
  logic [15:0] psw_q, vec_addr;
  logic        vec_take;
  logic [2:0]  vec_src;

  int n_cmp = 0, n_bad = 0;
  logic [18:0] exp_q[$];

  always #10 clk = ~clk;

  irq_vec_ctrl dut (
    .clk(clk), .rst(rst), .irq_hw(irq_hw), .insn_bnd(insn_bnd),
    .push_flags(push_flags), .pop_flags(pop_flags), .pop_data(pop_data),
    .psw_we(psw_we), .psw_wdata(psw_wdata), .reg_we(reg_we),
    .reg_sel(reg_sel), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .psw_q(psw_q), .vec_take(vec_take), .vec_src(vec_src), .vec_addr(vec_addr)
  );

  // monitor: every vector strobe is matched against the scoreboard
  always @(negedge clk) begin
    if (!rst && vec_take) begin
      n_cmp++;
      if (exp_q.size() == 0) begin
        n_bad++;
        $display("FAIL R3/R5: unexpected vector src=%0d addr=%h expected none",
                 vec_src, vec_addr);
      end else begin
        logic [18:0] e;
        e = exp_q.pop_front();
        if ({vec_src, vec_addr} !== e) begin
          n_bad++;
          $display("FAIL R4/R5: vector src=%0d addr=%h expected src=%0d addr=%h",
                   vec_src, vec_addr, e[18:16], e[15:0]);
        end
      end
    end
  end

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(negedge clk);
  endtask

  task automatic expect_vec(input int src);
    exp_q.push_back({3'(src), 16'h2000 + 16'(2 * src)});
  endtask

  task automatic bnd();
    insn_bnd = 1; cyc(); insn_bnd = 0;
  endtask

  task automatic hw(input logic [7:0] v);
    irq_hw = v; cyc(); irq_hw = '0;
  endtask

  task automatic set_psw(input logic [15:0] v);
    psw_we = 1; psw_wdata = v; cyc(); psw_we = 0;
  endtask

  task automatic rd(input logic sel, output logic [7:0] v);
    reg_sel = sel; cyc(); cyc(); v = reg_rdata;
  endtask

  initial begin
    logic [7:0] v;
    repeat (3) cyc();
    rst = 0;
    cyc();
    // R1 reset state
    chk("R1", psw_q, 16'h0000);
    chk("R1", {15'd0, vec_take}, 16'h0);
    rd(0, v); chk("R1", {8'd0, v}, 16'h0000);

    // R7 mask written through register port lands in status low byte
    reg_we = 1; reg_sel = 1; reg_wdata = 8'h5A; cyc(); reg_we = 0;
    chk("R7", psw_q, 16'h005A);
    rd(1, v); chk("R7", {8'd0, v}, 16'h005A);

    // R2/R3: pending without boundary is not taken
    set_psw(16'h02FF);
    hw(8'h08);
    rd(0, v); chk("R2", {8'd0, v}, 16'h0008);
    repeat (3) begin cyc(); chk("R3", {15'd0, vec_take}, 16'h0); end
    expect_vec(3); bnd();
    chk("R6", psw_q, 16'h00FF);
    rd(0, v); chk("R6", {8'd0, v}, 16'h0000);

    // R4 priority among three pending sources
    set_psw(16'h02FF);
    hw(8'h85);
    expect_vec(7); bnd();
    rd(0, v); chk("R4", {8'd0, v}, 16'h0005);
    set_psw(16'h02FF); expect_vec(2); bnd();
    set_psw(16'h02FF); expect_vec(0); bnd();
    rd(0, v); chk("R6", {8'd0, v}, 16'h0000);

    // R11 masked request waits
    set_psw(16'h0200);
    hw(8'h40);
    bnd(); chk("R11", {15'd0, vec_take}, 16'h0);
    rd(0, v); chk("R11", {8'd0, v}, 16'h0040);
    set_psw(16'h0240); expect_vec(6); bnd();
    rd(0, v); chk("R11", {8'd0, v}, 16'h0000);

    // R8 push clears the status word
    set_psw(16'hFEFF);
    push_flags = 1; cyc(); push_flags = 0;
    chk("R8", psw_q, 16'h0000);
    hw(8'h02);
    bnd(); chk("R8", {15'd0, vec_take}, 16'h0);

    // R9 pop together with its boundary: that boundary skipped, next taken
    pop_flags = 1; pop_data = 16'h02FF; insn_bnd = 1; cyc();
    pop_flags = 0; insn_bnd = 0;
    chk("R9", {15'd0, vec_take}, 16'h0);
    chk("R9", psw_q, 16'h02FF);
    expect_vec(1); bnd();

    // R9 pop ahead of its boundary
    hw(8'h01);
    pop_flags = 1; pop_data = 16'h02FF; cyc(); pop_flags = 0;
    bnd(); chk("R9", {15'd0, vec_take}, 16'h0);
    expect_vec(0); bnd();

    // R10 hardware set beats software write on the same bit
    reg_we = 1; reg_sel = 0; reg_wdata = 8'h00; irq_hw = 8'h20; cyc();
    reg_we = 0; irq_hw = 8'h00;
    rd(0, v); chk("R10", {8'd0, v}, 16'h0020);
    reg_we = 1; reg_sel = 0; reg_wdata = 8'h10; irq_hw = 8'h20; cyc();
    reg_we = 0; irq_hw = 8'h00;
    rd(0, v); chk("R10", {8'd0, v}, 16'h0030);
    reg_we = 1; reg_sel = 0; reg_wdata = 8'h00; cyc(); reg_we = 0;
    rd(0, v); chk("R2", {8'd0, v}, 16'h0000);

    repeat (2) cyc();
    chk("R5", 16'(exp_q.size()), 16'h0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule